// File: doc/BRIEF.md
# Run-Length Terminal Count LFSR Counter

This block is a free-running maximal-length counter built from an N-bit XOR-feedback linear feedback shift register. It raises a registered terminal-count pulse each time the register returns to the all-ones state. The all-ones state is the point at which one full period of 2^N-1 states closes.

A wide AND of all N state bits would put a deep gate tree in front of the terminal-count flop. The block avoids that with a small saturating counter of log2(N)+1 bits. The counter records how many ones in a row have entered the register. The register holds all ones exactly when the run length reaches N. The XOR form can never shift in N+1 ones in a row, so the pulse cannot arrive late. The bit shifted out just before all ones is always a zero, so the pulse cannot arrive early.

The register advances only in cycles where the enable is high. Reset loads all ones, which is not counted as a terminal state. The feedback taps come from a built-in table of maximal-length polynomials, or from a caller-supplied mask.

Top module: `lfsr_tco_counter`

## Requirements
- R1: While reset is asserted and on release, state is all ones, the run length is zero, and tco is low.
- R2: On each clock with en high, state becomes {fb, state[N-1:1]}. fb is the XOR of the state bits selected by the tap mask. For N=4 the mask selects bits 0 and 1. For N=16 it selects bits 0, 11, 13 and 14.
- R3: With en held high, state never becomes all zeros, and it revisits all ones every 2^N-1 enabled clocks (15 for N=4, 65535 for N=16).
- R4: On a clock with en low, state keeps its value and tco is low in the following cycle.
- R5: tco is high in exactly those cycles that follow an enabled shift which left state all ones.
- R6: tco is a single-cycle pulse: it is never high in two consecutive cycles.
- R7: The run length clears when a zero is shifted in, increments when a one is shifted in, and saturates rather than wrapping. It never exceeds N, and it is preserved across clocks with en low, so tco stays correct when the enable is gated.
- R8: The all-ones value loaded by reset raises no pulse. The first tco after reset comes after exactly 2^N-1 enabled shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance the register by one step this clock |
| state | output | N | Current register contents |
| tco | output | 1 | Registered terminal-count pulse, high while state is a freshly reached all-ones value |

## Verification
The hardest situation to reach from the ports is the terminal count of a wide register. For N=16 the run counter must climb through the only stretch of sixteen consecutive ones, which lies 65535 enabled shifts away from reset. The bench therefore drives one uninterrupted enabled run of a full period plus a few steps on a 16-bit instance. It compares tco in every cycle against a direct all-ones compare of a model register. A second difficulty is a run of ones split by enable gaps. A repeating gated enable pattern on the 4-bit instance stops the register partway through runs, and then checks that detection still lands on the right cycle.

// File: rtl/lfsr_tco_pkg.sv
`timescale 1ns/1ps
package lfsr_tco_pkg;

   localparam int MAX_WIDTH = 64;

   // Returns a tap mask for a maximal-length polynomial x^n + sum(x^j).
   // Bit j of the mask selects state bit j into the feedback XOR.
   // A zero return means no table entry for this width.
   function automatic logic [MAX_WIDTH-1:0] default_taps(input int n);
      logic [MAX_WIDTH-1:0] m;
      m = '0;
      case (n)
         3:  m = 64'h3;
         4:  m = 64'h3;
         5:  m = 64'h5;
         6:  m = 64'h3;
         7:  m = 64'h3;
         8:  m = 64'h1D;
         9:  m = 64'h11;
         10: m = 64'h9;
         11: m = 64'h5;
         15: m = 64'h3;
         16: m = 64'h6801;
         17: m = 64'h9;
         32: m = 64'h400007;
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/lfsr_shift_reg.sv
`timescale 1ns/1ps
module lfsr_shift_reg #(
   parameter int             N    = 4,
   parameter logic [N-1:0]   TAPS = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   output logic [N-1:0] state_q,
   output logic         fb
);

   // XOR tree over the selected taps, built as a chain of partial sums.
   logic [N:0] part;
   assign part[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_tap
      if (TAPS[i]) begin : g_use
         assign part[i+1] = part[i] ^ state_q[i];
      end else begin : g_skip
         assign part[i+1] = part[i];
      end
   end

   assign fb = part[N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '1;
      end else if (en) begin
         state_q <= {fb, state_q[N-1:1]};
      end
   end

endmodule

// File: rtl/lfsr_run_counter.sv
`timescale 1ns/1ps
module lfsr_run_counter #(
   parameter int N = 4,
   parameter int W = $clog2(N) + 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         bit_in,
   output logic [W-1:0] run_q,
   output logic         term_hit
);

   localparam logic [W-1:0] RUN_MAX  = '1;
   localparam logic [W-1:0] RUN_TERM = W'(N - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (en) begin
         if (!bit_in) begin
            run_q <= '0;
         end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   // The N-th consecutive one is about to enter: the register becomes all ones.
   assign term_hit = en & bit_in & (run_q == RUN_TERM);

endmodule

// File: rtl/lfsr_tco_flag.sv
`timescale 1ns/1ps
module lfsr_tco_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   output logic tco_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tco_q <= 1'b0;
      end else begin
         tco_q <= hit;
      end
   end

endmodule

// File: rtl/lfsr_tco_counter.sv
`timescale 1ns/1ps
module lfsr_tco_counter #(
   parameter int           N        = 4,
   parameter logic [N-1:0] TAP_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   output logic [N-1:0] state,
   output logic         tco
);

   import lfsr_tco_pkg::*;

   localparam int           W        = $clog2(N) + 1;
   localparam logic [N-1:0] TABLE_TAPS = N'(default_taps(N));
   localparam logic [N-1:0] TAPS     = (TAP_MASK != '0) ? TAP_MASK : TABLE_TAPS;

   // Elaboration-time parameter checks.
   if (N < 3 || N > MAX_WIDTH) begin : g_bad_width
      $error("lfsr_tco_counter: N out of range");
   end
   if (TAPS == '0) begin : g_no_taps
      $error("lfsr_tco_counter: no tap mask for this width");
   end
   if (TAPS[0] != 1'b1) begin : g_bad_bit0
      $error("lfsr_tco_counter: tap mask must include bit 0");
   end
   if (($countones(TAPS) % 2) != 0) begin : g_odd_taps
      $error("lfsr_tco_counter: tap count must be even for all-ones to leave");
   end

   logic [N-1:0] state_q;
   logic         fb;
   logic [W-1:0] run_len;
   logic         term_hit;

   lfsr_shift_reg #(.N(N), .TAPS(TAPS)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .state_q (state_q),
      .fb      (fb)
   );

   lfsr_run_counter #(.N(N), .W(W)) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .bit_in   (fb),
      .run_q    (run_len),
      .term_hit (term_hit)
   );

   lfsr_tco_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (term_hit),
      .tco_q (tco)
   );

   assign state = state_q;

endmodule

// File: rtl/lfsr_tco_counter_chk.sv
`timescale 1ns/1ps
module lfsr_tco_counter_chk #(
   parameter int N = 4,
   parameter int W = $clog2(N) + 1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         en,
   input logic [N-1:0] state,
   input logic         tco,
   input logic [W-1:0] run_len
);

   localparam logic [N-1:0] ALL_ONES = '1;
   localparam logic [N-1:0] PRE_TERM = {{(N-1){1'b1}}, 1'b0};
   localparam logic [W-1:0] RUN_N    = W'(N);

   AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> state[N-2:0] == $past(state[N-1:1]));                    // R2

   AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);                                                     // R3

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(state) && !tco));                                // R4

   AST_TCO_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      tco |-> state == ALL_ONES);                                       // R5

   AST_TCO_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
      (en && state == PRE_TERM) |=> tco);                               // R5

   AST_TCO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tco |=> !tco);                                                    // R6

   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= RUN_N);                                                // R7

   AST_RUN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ((run_len == '0) == !state[N-1]));                         // R7

endmodule

bind lfsr_tco_counter lfsr_tco_counter_chk #(.N(N), .W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (en),
   .state   (state),
   .tco     (tco),
   .run_len (run_len)
);

// File: tb/test_lfsr_tco_counter.sv
`timescale 1ns/1ps
module test_lfsr_tco_counter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en4 = 1'b0;
   logic        en16 = 1'b0;
   logic [3:0]  state4;
   logic        tco4;
   logic [15:0] state16;
   logic        tco16;

   int n_tests = 0;
   int n_fail  = 0;

   logic [3:0]  m4;
   logic [15:0] m16;
   logic        x4, x16;

   always #5 clk = ~clk;

   lfsr_tco_counter #(.N(4)) i_lfsr_tco_counter (
      .clk(clk), .rst_n(rst_n), .en(en4), .state(state4), .tco(tco4));

   lfsr_tco_counter #(.N(16)) i_lfsr_tco_counter_w16 (
      .clk(clk), .rst_n(rst_n), .en(en16), .state(state16), .tco(tco16));

   // Expected {state, tco} after each enabled step from reset, N=4.
   localparam logic [4:0] VEC4 [15] = '{
      5'b0111_0, 5'b0011_0, 5'b0001_0, 5'b1000_0, 5'b0100_0,
      5'b0010_0, 5'b1001_0, 5'b1100_0, 5'b0110_0, 5'b1011_0,
      5'b0101_0, 5'b1010_0, 5'b1101_0, 5'b1110_0, 5'b1111_1 };

   task automatic check(input logic ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; en4 = 1'b0; en16 = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m4 = 4'hF; m16 = 16'hFFFF; x4 = 1'b0; x16 = 1'b0;
   endtask

   // One clock; models advance independently of the design.
   task automatic step(input logic e4, input logic e16);
      @(negedge clk);
      en4 = e4; en16 = e16;
      @(posedge clk);
      #1;
      if (e4)  m4  = {m4[0] ^ m4[1], m4[3:1]};
      if (e16) m16 = {m16[0] ^ m16[11] ^ m16[13] ^ m16[14], m16[15:1]};
      x4  = e4  && (m4  == 4'hF);
      x16 = e16 && (m16 == 16'hFFFF);
   endtask

   initial begin
      #1_500_000;
      n_fail++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      m4 = 4'hF; m16 = 16'hFFFF; x4 = 1'b0; x16 = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      // R1: values while reset is held
      check(state4 == 4'hF && !tco4, "R1 reset held n4", {27'd0, tco4, state4}, 32'hF);
      check(state16 == 16'hFFFF && !tco16, "R1 reset held n16", {15'd0, tco16, state16}, 32'hFFFF);
      rst_n = 1'b1;
      @(negedge clk);
      check(state4 == 4'hF && !tco4, "R1 after release", {27'd0, tco4, state4}, 32'hF);

      // R2 R3 R5 R8: table walk over two periods; 16-bit instance idle (R4)
      for (int i = 0; i < 30; i++) begin
         step(1'b1, 1'b0);
         check({state4, tco4} == VEC4[i % 15], "R2/R5 table",
               {27'd0, state4, tco4}, {27'd0, VEC4[i % 15]});
         check(state16 == 16'hFFFF && !tco16, "R4 idle n16",
               {15'd0, tco16, state16}, 32'hFFFF);
      end

      // R7 R4: gated enable, pulse must still land correctly
      for (int i = 0; i < 90; i++) begin
         logic e;
         e = ((i % 3) != 1) && ((i % 7) != 5);
         step(e, 1'b0);
         check(state4 == m4, "R7 gated state", {28'd0, state4}, {28'd0, m4});
         check(tco4 == x4, "R7 gated tco", {31'd0, tco4}, {31'd0, x4});
         if (!e) check(!tco4, "R4 tco low when idle", {31'd0, tco4}, 32'd0);
      end

      // R1 R8: reset mid-run, first pulse exactly 15 steps later
      do_reset();
      #1;
      check(state4 == 4'hF && !tco4, "R1 reset mid-run", {27'd0, tco4, state4}, 32'hF);
      for (int i = 1; i <= 15; i++) begin
         step(1'b1, 1'b0);
         check(tco4 == (i == 15), "R8 first pulse n4", {31'd0, tco4}, {31'd0, (i == 15)});
      end

      // R3 R5 R6 R8: full period of the 16-bit instance
      do_reset();
      begin
         int pulses;
         int first_at;
         logic prev;
         pulses = 0; first_at = -1; prev = 1'b0;
         for (int i = 1; i <= 65540; i++) begin
            step(1'b0, 1'b1);
            if (state16 != m16 || tco16 != x16 || state16 == 16'h0)
               check(1'b0, "R3/R5 n16 state or tco",
                     {15'd0, tco16, state16}, {15'd0, x16, m16});
            if (tco16 && prev)
               check(1'b0, "R6 double pulse", 32'd1, 32'd0);
            if (tco16) begin
               pulses++;
               if (first_at < 0) first_at = i;
            end
            prev = tco16;
         end
         check(first_at == 65535, "R8 first pulse n16", first_at, 32'd65535);
         check(pulses == 1, "R3 one pulse per period", pulses, 32'd1);
         check(state16 == m16, "R3 n16 end state", {16'd0, state16}, {16'd0, m16});
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule